// File: doc/BRIEF.md
# Key-Locked Commit Register Guard

This block guards one configuration register of an 8-pin I/O port: the alternate-function select, which hands each pin to a peripheral instead of the general-purpose logic. Each bit of that register can only change when the matching bit of an 8-bit commit mask is set. The commit mask can only be rewritten while the guard is unlocked.

To unlock the guard, software writes a fixed 32-bit key to a lock register. Writing any other value to that register locks the guard again. Software reaches the three registers through a simple write/read port with an address, write data, a write strobe and read data. The current alternate-function value is also driven out to the pad logic.

Top module: `keylock_guard`

## Requirements
- R1: After reset the guard is locked (lock register reads 1), the commit mask reads 0xFF and the alternate-function register reads 0x00.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) unlocks the guard, so the lock register then reads 0.
- R3: A write of any other value to the lock register locks the guard, so the lock register then reads 1.
- R4: A read of the lock register returns 1 in bit 0 while locked and 0 while unlocked, with all upper bits zero.
- R5: A write to the commit register (offset 0x524) while locked leaves the commit mask unchanged.
- R6: A write to the commit register while unlocked stores the low 8 bits of the write data, and reads return that value zero-extended.
- R7: A write to the alternate-function register (offset 0x420) updates only the bits whose commit-mask bit is 1. The other bits keep their old value, and `alt_sel` always equals the register.
- R8: Locking the guard again does not change the commit mask.
- R9: Writes take effect at the rising clock edge, and `rd_data` follows `addr` combinationally from the stored state.
- R10: A read of any other address returns 0, and a write to any other address changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset of the register accessed |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| rd_data | output | 32 | Combinational read data for `addr` |
| alt_sel | output | 8 | Current alternate-function select bits |

## Verification
The assertions assume that `addr`, `wr_data` and `wr_en` are stable and known at every rising edge once reset is released, and that a write lasts exactly the cycles `wr_en` is high. The bench changes these inputs only on the falling edge and holds `wr_en` high for a single cycle per write. All of its writes and reads use the three decoded offsets plus one unused offset.

// File: rtl/keylock_guard.sv
module keylock_guard #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int PORT_W   = 8,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551,
  parameter logic [ADDR_W-1:0] OFS_ALT    = 12'h420,
  parameter logic [ADDR_W-1:0] OFS_LOCK   = 12'h520,
  parameter logic [ADDR_W-1:0] OFS_COMMIT = 12'h524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PORT_W-1:0] alt_sel
);

  localparam logic [PORT_W-1:0] MASK_RST = {PORT_W{1'b1}};
  localparam int PAD_W = DATA_W - PORT_W;

  logic              locked;
  logic [PORT_W-1:0] commit_mask;
  logic [PORT_W-1:0] alt_q;

  wire hit_lock   = wr_en && (addr == OFS_LOCK);
  wire hit_commit = wr_en && (addr == OFS_COMMIT);
  wire hit_alt    = wr_en && (addr == OFS_ALT);
  wire [PORT_W-1:0] wr_byte = wr_data[PORT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked      <= 1'b1;
      commit_mask <= MASK_RST;
      alt_q       <= '0;
    end else begin
      if (hit_lock)
        locked <= (wr_data != UNLOCK_KEY);
      if (hit_commit && !locked)
        commit_mask <= wr_byte;
      if (hit_alt)
        alt_q <= (alt_q & ~commit_mask) | (wr_byte & commit_mask);
    end
  end

  assign alt_sel = alt_q;

  always_comb begin
    rd_data = '0;
    if (addr == OFS_LOCK)        rd_data = {{(DATA_W-1){1'b0}}, locked};
    else if (addr == OFS_COMMIT) rd_data = {{PAD_W{1'b0}}, commit_mask};
    else if (addr == OFS_ALT)    rd_data = {{PAD_W{1'b0}}, alt_q};
  end

  p_unlock_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LOCK && wr_data == UNLOCK_KEY) |=> !locked);

  p_relock_on_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LOCK && wr_data != UNLOCK_KEY) |=> locked);

  p_commit_held_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_COMMIT && locked) |=> $stable(commit_mask));

  p_alt_masked_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ALT) |=>
      (((alt_sel ^ $past(alt_sel)) & ~$past(commit_mask)) == '0));

  p_mask_only_by_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_COMMIT) |=> $stable(commit_mask));

  p_alt_only_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_ALT) |=> $stable(alt_sel));

endmodule

// File: tb/keylock_guard_test.sv
module keylock_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  alt_sel;

  keylock_guard uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_data(rd_data), .alt_sel(alt_sel)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_locked = 1;
  int m_mask   = 255;
  int m_alt    = 0;

  localparam logic [11:0] A_ALT = 12'h420, A_LOCK = 12'h520, A_COMMIT = 12'h524;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference update for one write, in plain integer arithmetic
  task automatic model_write(logic [11:0] a, logic [31:0] d);
    if (a == A_LOCK) m_locked = (d == 32'h0ACCE551) ? 0 : 1;
    else if (a == A_COMMIT) begin
      if (m_locked == 0) m_mask = d % 256;
    end else if (a == A_ALT) begin
      int nv = 0;
      for (int b = 0; b < 8; b++) begin
        int src = ((m_mask >> b) & 1) ? ((d >> b) & 1) : ((m_alt >> b) & 1);
        nv += src << b;
      end
      m_alt = nv;
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 check(req, rd_data, exp);
  endtask

  // Per-cycle comparison of the pad output with the reference (R7)
  always @(negedge clk) if (rst_n && !done) check("R7 alt_sel", {24'h0, alt_sel}, m_alt);

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd("R1 lock", A_LOCK, 32'd1);
    rd("R1 commit", A_COMMIT, 32'hFF);
    rd("R1 alt", A_ALT, 32'h00);
    wr(A_ALT, 32'hFFFF_FFA5);
    rd("R7 alt full mask", A_ALT, 32'hA5);
    wr(A_COMMIT, 32'h0F);
    rd("R5 commit locked", A_COMMIT, 32'hFF);
    wr(A_LOCK, 32'h0ACC_E550);
    rd("R3 near-key", A_LOCK, 32'd1);
    wr(A_LOCK, 32'h0ACC_E551);
    rd("R2 R4 unlocked", A_LOCK, 32'd0);
    wr(A_COMMIT, 32'h1234_563C);
    rd("R6 commit low byte", A_COMMIT, 32'h3C);
    wr(A_ALT, 32'h5A);
    rd("R7 partial mask", A_ALT, 32'h99);
    wr(A_LOCK, 32'h0);
    rd("R3 R4 relocked", A_LOCK, 32'd1);
    rd("R8 mask kept", A_COMMIT, 32'h3C);
    wr(A_COMMIT, 32'h00);
    rd("R5 commit relocked", A_COMMIT, 32'h3C);
    wr(A_ALT, 32'hFF);
    rd("R7 masked set", A_ALT, 32'hBD);
    wr(12'h400, 32'hFFFF_FFFF);
    rd("R10 unknown read", 12'h400, 32'h0);
    rd("R10 alt untouched", A_ALT, 32'hBD);
    rd("R10 lock untouched", A_LOCK, 32'd1);
    // R9: value changes only at the edge; read path is combinational
    @(negedge clk);
    addr = A_ALT; wr_data = 32'h00; wr_en = 1'b1;
    #1 check("R9 before edge", rd_data, 32'hBD);
    @(posedge clk);
    model_write(A_ALT, 32'h00);
    #1 check("R9 after edge", rd_data, 32'h81);
    @(negedge clk) wr_en = 1'b0;
    addr = A_COMMIT;
    #1 check("R9 comb read", rd_data, 32'h3C);
    @(negedge clk);
    finish_run();
  end

endmodule